// File: doc/BRIEF.md
# LCD Frame Scan Controller

This block sequences pixels for a raster LCD panel. Software programs two values: a line width code, giving a width of 16 to 1024 pixels in steps of 16, and the total number of pixels in one frame. The number of lines is never programmed. A frame simply ends when the programmed pixel total has been emitted. If that total is not a whole number of lines, the last line is cut short.

Pixel words come from the head of a FIFO that an external DMA channel keeps filled. On every cycle in which the pixel clock enable is high, the block pops one word and presents it one cycle later, together with a valid flag and two strobes. The line strobe marks the first pixel of each line, and the frame strobe marks the first pixel of each frame.

If the FIFO is empty when a pixel is due, the block emits a zero pixel and raises a sticky underflow flag. Configuration inputs are sampled only on the first pixel of a frame, so a mid-frame write changes nothing until the next frame begins.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: A line holds (cfg_width_code + 1) × 16 pixels. line_start is high on a pixel exactly when that pixel's index within the frame, counted from 0, is a multiple of the line width.
- R2: A frame holds exactly cfg_total_pixels pixels. frame_start is high only on pixel index 0. When the total is not a multiple of the width, the last line is shorter and the next pixel starts a new frame.
- R3: Each cycle with pix_ce high and a non-zero active total emits one pixel. pix_valid goes high in the following cycle and is low in every other cycle.
- R4: fifo_rd is high, combinationally, exactly when a pixel is due and fifo_empty is low. The word on fifo_data in that cycle appears on pix_data in the next cycle.
- R5: A pixel due while fifo_empty is high does not assert fifo_rd and is output as all zeros. underflow becomes set in the next cycle and stays set until reset.
- R6: cfg_width_code and cfg_total_pixels are sampled only when the first pixel of a frame is due. Changes made during a frame do not alter its line length or its end.
- R7: A total of zero, once it is sampled at a frame boundary, emits no pixels and never asserts fifo_rd. It is re-sampled on every enabled cycle until it becomes non-zero.
- R8: After reset, pix_valid, line_start, frame_start, pix_data and underflow are low, and the first emitted pixel carries frame_start and line_start.
- R9: cfg_total_pixels is 21 bits wide, enough for a 1024 × 1024 frame, and the 1024-pixel line width (code 63) sequences correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width_code | input | 6 | Line width code, width = (code+1)×16 |
| cfg_total_pixels | input | 21 | Pixels per frame |
| pix_ce | input | 1 | Pixel clock enable, one pixel per high cycle |
| fifo_data | input | DATA_W | Word at the FIFO head |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| pix_data | output | DATA_W | Pixel word |
| pix_valid | output | 1 | pix_data holds a pixel |
| line_start | output | 1 | First pixel of a line |
| frame_start | output | 1 | First pixel of a frame |
| underflow | output | 1 | Sticky: a pixel was due while the FIFO was empty |

## Verification
The assertions assume that fifo_data is valid whenever fifo_empty is low. They also assume that the FIFO accepts a pop in any cycle in which it is non-empty, so the block never has to wait before reading.

The bench models the FIFO itself, so it holds to both assumptions by construction. It always presents the next word of its own sequence and raises fifo_empty only on purpose to provoke underflow.

Configuration may change in any cycle, and the bench does this deliberately in the middle of frames. Its reference model samples the settings at frame boundaries just as R6 requires.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int CODE_W    = 6;
  localparam int UNIT_LOG2 = 4;
  localparam int COL_W     = CODE_W + UNIT_LOG2 + 1;
  localparam int TOTAL_W   = 2 * (CODE_W + UNIT_LOG2) + 1;

  // pixels in one line for a given width code
  function automatic logic [COL_W-1:0] line_pixels(input logic [CODE_W-1:0] code);
    logic [COL_W-1:0] units;
    units = COL_W'(code) + COL_W'(1);
    return units << UNIT_LOG2;
  endfunction

  function automatic logic line_last(input logic [COL_W-1:0] col,
                                     input logic [CODE_W-1:0] code);
    return col == (line_pixels(code) - COL_W'(1));
  endfunction

  function automatic logic frame_last(input logic [TOTAL_W-1:0] pos,
                                      input logic [TOTAL_W-1:0] total);
    return pos == (total - TOTAL_W'(1));
  endfunction
endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
  import lcd_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               at_boundary,
  input  logic               take,
  input  logic [CODE_W-1:0]  cfg_code,
  input  logic [TOTAL_W-1:0] cfg_total,
  output logic [CODE_W-1:0]  act_code,
  output logic [TOTAL_W-1:0] act_total,
  output logic [CODE_W-1:0]  cur_code,
  output logic [TOTAL_W-1:0] cur_total
);
  // at a frame boundary the live inputs govern the first pixel
  assign cur_code  = at_boundary ? cfg_code  : act_code;
  assign cur_total = at_boundary ? cfg_total : act_total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code  <= '0;
      act_total <= '0;
    end else if (take) begin
      act_code  <= cfg_code;
      act_total <= cfg_total;
    end
  end
endmodule

// File: rtl/lcd_scan_counters.sv
module lcd_scan_counters
  import lcd_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [CODE_W-1:0]  cur_code,
  input  logic [TOTAL_W-1:0] cur_total,
  output logic [COL_W-1:0]   col_q,
  output logic [TOTAL_W-1:0] pos_q,
  output logic               at_boundary,
  output logic               line_first
);
  logic end_of_frame;
  logic end_of_line;

  assign at_boundary  = (pos_q == '0);
  assign line_first   = (col_q == '0);
  assign end_of_frame = frame_last(pos_q, cur_total);
  assign end_of_line  = line_last(col_q, cur_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      col_q <= '0;
    end else if (step) begin
      if (end_of_frame) begin
        pos_q <= '0;
        col_q <= '0;
      end else begin
        pos_q <= pos_q + TOTAL_W'(1);
        col_q <= end_of_line ? '0 : col_q + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_pixel_out.sv
module lcd_pixel_out #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              due,
  input  logic              line_first,
  input  logic              frame_first,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic              underflow_evt,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              line_start,
  output logic              frame_start,
  output logic              underflow
);
  assign fifo_rd       = due & ~fifo_empty;
  assign underflow_evt = due & fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_data    <= '0;
      pix_valid   <= 1'b0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
      underflow   <= 1'b0;
    end else begin
      pix_valid   <= due;
      line_start  <= due & line_first;
      frame_start <= due & frame_first;
      pix_data    <= fifo_rd ? fifo_data : '0;
      underflow   <= underflow | underflow_evt;
    end
  end
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  cfg_width_code,
  input  logic [TOTAL_W-1:0] cfg_total_pixels,
  input  logic               pix_ce,
  input  logic [DATA_W-1:0]  fifo_data,
  input  logic               fifo_empty,
  output logic               fifo_rd,
  output logic [DATA_W-1:0]  pix_data,
  output logic               pix_valid,
  output logic               line_start,
  output logic               frame_start,
  output logic               underflow
);
  // named internal events, also used by the checker
  logic [CODE_W-1:0]  act_code;
  logic [TOTAL_W-1:0] act_total;
  logic [CODE_W-1:0]  cur_code;
  logic [TOTAL_W-1:0] cur_total;
  logic [COL_W-1:0]   col_q;
  logic [TOTAL_W-1:0] pos_q;
  logic               at_boundary;
  logic               line_first;
  logic               frame_take;
  logic               pixel_due;
  logic               underflow_evt;

  assign frame_take = pix_ce & at_boundary;
  assign pixel_due  = pix_ce & (cur_total != '0);

  lcd_cfg_shadow u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .at_boundary (at_boundary),
    .take        (frame_take),
    .cfg_code    (cfg_width_code),
    .cfg_total   (cfg_total_pixels),
    .act_code    (act_code),
    .act_total   (act_total),
    .cur_code    (cur_code),
    .cur_total   (cur_total)
  );

  lcd_scan_counters u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (pixel_due),
    .cur_code    (cur_code),
    .cur_total   (cur_total),
    .col_q       (col_q),
    .pos_q       (pos_q),
    .at_boundary (at_boundary),
    .line_first  (line_first)
  );

  lcd_pixel_out #(.DATA_W(DATA_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .due           (pixel_due),
    .line_first    (line_first),
    .frame_first   (at_boundary),
    .fifo_empty    (fifo_empty),
    .fifo_data     (fifo_data),
    .fifo_rd       (fifo_rd),
    .underflow_evt (underflow_evt),
    .pix_data      (pix_data),
    .pix_valid     (pix_valid),
    .line_start    (line_start),
    .frame_start   (frame_start),
    .underflow     (underflow)
  );
endmodule

// File: rtl/lcd_scan_checker.sv
module lcd_scan_checker
  import lcd_scan_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_ce,
  input logic               fifo_empty,
  input logic               fifo_rd,
  input logic [DATA_W-1:0]  pix_data,
  input logic               pix_valid,
  input logic               line_start,
  input logic               frame_start,
  input logic               underflow,
  input logic               underflow_evt,
  input logic               frame_take,
  input logic               at_boundary,
  input logic [CODE_W-1:0]  act_code,
  input logic [TOTAL_W-1:0] act_total,
  input logic [TOTAL_W-1:0] cur_total,
  input logic [COL_W-1:0]   col_q,
  input logic [TOTAL_W-1:0] pos_q
);
  a_r1_col_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    !at_boundary |-> (col_q < line_pixels(act_code)));

  a_r2_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !at_boundary |-> (pos_q < act_total));

  a_r2_frame_is_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);

  a_r3_valid_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> !pix_valid);

  a_r4_read_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (!fifo_empty && pix_ce));

  a_r5_zero_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |=> (pix_valid && pix_data == '0 && underflow));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  a_r6_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_take |=> ($stable(act_code) && $stable(act_total)));

  a_r7_zero_total_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_total == '0) |-> !fifo_rd);
endmodule

bind lcd_scan_ctrl lcd_scan_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pix_ce        (pix_ce),
  .fifo_empty    (fifo_empty),
  .fifo_rd       (fifo_rd),
  .pix_data      (pix_data),
  .pix_valid     (pix_valid),
  .line_start    (line_start),
  .frame_start   (frame_start),
  .underflow     (underflow),
  .underflow_evt (underflow_evt),
  .frame_take    (frame_take),
  .at_boundary   (at_boundary),
  .act_code      (act_code),
  .act_total     (act_total),
  .cur_total     (cur_total),
  .col_q         (col_q),
  .pos_q         (pos_q)
);

// File: tb/test_lcd_scan_ctrl.sv
module test_lcd_scan_ctrl;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    cfg_width_code = '0;
  logic [20:0]   cfg_total_pixels = '0;
  logic          pix_ce = 1'b0;
  logic [DW-1:0] fifo_data = '0;
  logic          fifo_empty = 1'b0;
  logic          fifo_rd;
  logic [DW-1:0] pix_data;
  logic          pix_valid;
  logic          line_start;
  logic          frame_start;
  logic          underflow;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  string g_tag = "base";

  // reference model state
  int     m_pos = 0;
  int     m_w = 0;
  int     m_t = 0;
  bit     m_uf = 1'b0;
  logic [DW-1:0] m_word = 16'h1000;

  always #10 clk = ~clk;

  lcd_scan_ctrl #(.DATA_W(DW)) i_lcd_scan_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_width_code   (cfg_width_code),
    .cfg_total_pixels (cfg_total_pixels),
    .pix_ce           (pix_ce),
    .fifo_data        (fifo_data),
    .fifo_empty       (fifo_empty),
    .fifo_rd          (fifo_rd),
    .pix_data         (pix_data),
    .pix_valid        (pix_valid),
    .line_start       (line_start),
    .frame_start      (frame_start),
    .underflow        (underflow)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h cycle=%0d", req, g_tag, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pix_ce = 1'b0;
    fifo_empty = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_pos = 0; m_w = 0; m_t = 0; m_uf = 1'b0;
    @(negedge clk);
  endtask

  // one cycle: drive at negedge, check the registered result at the next negedge
  task automatic run_cycle(input bit ce, input bit empty);
    int  cw, ct, lw;
    bit  due, exp_rd;
    logic [DW-1:0] exp_data;
    bit  exp_ls, exp_fs;
    pix_ce = ce;
    fifo_empty = empty;
    fifo_data = m_word;
    cw = (m_pos == 0) ? int'(cfg_width_code) : m_w;
    ct = (m_pos == 0) ? int'(cfg_total_pixels) : m_t;
    lw = (cw + 1) * 16;
    due = ce && (ct != 0);
    exp_rd = due && !empty;
    exp_ls = due && ((m_pos % lw) == 0);
    exp_fs = due && (m_pos == 0);
    exp_data = exp_rd ? m_word : '0;
    #1;
    chk(fifo_rd == exp_rd, "R4", fifo_rd, exp_rd);
    if (ce && m_pos == 0) begin
      m_w = cw;
      m_t = ct;
    end
    if (due) begin
      m_pos = (m_pos + 1 == ct) ? 0 : m_pos + 1;
      if (empty) m_uf = 1'b1;
    end
    if (exp_rd) m_word = m_word + 16'h0001;
    @(negedge clk);
    cyc++;
    chk(pix_valid == due, "R3", pix_valid, due);
    chk(line_start == exp_ls, "R1", line_start, exp_ls);
    chk(frame_start == exp_fs, "R2", frame_start, exp_fs);
    if (due) chk(pix_data == exp_data, empty ? "R5" : "R4", pix_data, exp_data);
    chk(underflow == m_uf, "R5", underflow, m_uf);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int totals[7] = '{1, 15, 16, 17, 40, 64, 100};
    // R8: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(pix_valid == 1'b0 && line_start == 1'b0 && frame_start == 1'b0, "R8", pix_valid, 0);
    chk(underflow == 1'b0 && pix_data == '0, "R8", underflow, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_rd == 1'b0, "R8", fifo_rd, 0);
    cfg_width_code = 6'd0;
    cfg_total_pixels = 21'd20;
    g_tag = "R8";
    run_cycle(1'b1, 1'b0);
    chk(frame_start && line_start, "R8", {frame_start, line_start}, 2'b11);

    // R1 R2 R3: sweep widths and totals, with gaps in the pixel enable
    g_tag = "sweep";
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 7; k++) begin
        cfg_width_code = 6'(c);
        cfg_total_pixels = 21'(totals[k]);
        for (int n = 0; n < 2 * totals[k] * 4 / 3 + 12; n++)
          run_cycle((n % 4) != 3, 1'b0);
      end
    end

    // R6: mid-frame configuration change
    do_reset();
    g_tag = "R6";
    cfg_width_code = 6'd1;
    cfg_total_pixels = 21'd96;
    for (int n = 0; n < 10; n++) run_cycle(1'b1, 1'b0);
    cfg_width_code = 6'd0;
    cfg_total_pixels = 21'd20;
    for (int n = 0; n < 86; n++) run_cycle(1'b1, 1'b0);
    chk(m_pos == 0, "R6", m_pos, 0);
    run_cycle(1'b1, 1'b0);
    chk(frame_start == 1'b1, "R6", frame_start, 1);
    for (int n = 0; n < 45; n++) run_cycle(1'b1, 1'b0);

    // R7: zero total
    g_tag = "R7";
    cfg_total_pixels = 21'd0;
    for (int n = 0; n < 60; n++) run_cycle(1'b1, 1'b0);
    chk(pix_valid == 1'b0, "R7", pix_valid, 0);
    cfg_total_pixels = 21'd5;
    for (int n = 0; n < 12; n++) run_cycle(1'b1, 1'b0);

    // R9: widest line, truncated last line
    do_reset();
    g_tag = "R9";
    cfg_width_code = 6'd63;
    cfg_total_pixels = 21'd2055;
    for (int n = 0; n < 2100; n++) run_cycle(1'b1, 1'b0);

    // R5: underflow
    do_reset();
    g_tag = "R5";
    cfg_width_code = 6'd0;
    cfg_total_pixels = 21'd33;
    for (int n = 0; n < 20; n++) run_cycle(1'b1, 1'b0);
    chk(underflow == 1'b0, "R5", underflow, 0);
    for (int n = 0; n < 60; n++) run_cycle((n % 5) != 0, (n % 7) == 3);
    chk(underflow == 1'b1, "R5", underflow, 1);
    for (int n = 0; n < 20; n++) run_cycle(1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule